// File: doc/BRIEF.md
# Three-Channel Timer Counter

This block holds three identical 16-bit up-counters that share one word-addressed register bus. Each channel picks its count source from a fixed set of internal clock enables or from one of three external clock lines. The internal set is the system clock divided by 2, 8, 32 and 128, plus the rising edges of a slow clock input. The counter advances by one on each selected enable. It can report a match against a programmable compare value, and it can reload to zero on that match. A sticky flag records each wrap past the top of the range. The enabled flags drive the channel's interrupt line.

Two block-wide controls act on every channel. A block start write clears and starts all counters on the same clock edge. A block mode register can feed each external clock line from the first timer output of a neighbouring channel instead of from its pin. This chains channels to extend the count range or to divide an event stream. Each channel has two bidirectional timer lines. The A line carries a level that toggles on every compare match. The B line drives a static programmed level. Output enables for both lines are set by software, and both input levels can be read back.

Top module: `tmr_block`

## Requirements
- R1: After reset, every counter reads 0, every channel is stopped, all flags are clear, every irq is low and all timer line output enables are low.
- R2: Writing bit 0 of a channel's control word (word ch*8+0) clears its counter to 0 and starts it. Writing bit 1 stops it, and a stopped counter holds its value whatever its clock does.
- R3: Mode field bits [2:0] (word ch*8+1) set the count source. Codes 0, 1, 2 and 3 select the system clock divided by 2, 8, 32 and 128. Code 4 selects rising edges of slow_clk. A running counter advances by exactly one per enable.
- R4: Codes 5, 6 and 7 select external clock lines XC0, XC1 and XC2. Pin sources pass through a two-flop synchronizer, and the counter advances once per rising edge.
- R5: When a running counter at 0xFFFF receives an enable, it wraps to 0 and sets the sticky overflow flag, status bit 0 (word ch*8+4).
- R6: An enable that arrives while the counter equals the compare word (word ch*8+2) sets the compare flag (status bit 1) and toggles the channel's A line level. With mode bit 6 set, that enable reloads the counter to 0 instead of incrementing it.
- R7: Reading the status word returns the flags in bits 1:0, the running bit in bit 8, and the synchronized A and B input levels in bits 9 and 10. The read clears bits 1:0. A flag raised on the same edge is kept.
- R8: Each irq output is the OR of the channel's flags masked by its enable word (word ch*8+5, bit 0 overflow, bit 1 compare). A masked flag leaves irq low.
- R9: Writing bit 0 of the block control word (word 24) clears and starts all three counters on the same edge.
- R10: Bit i of the block mode word (word 25) set to 1 sources XCi from the A line level of channel (i+2) mod 3. Set to 0, XCi comes from pin tclk[i].
- R11: Mode bit 3 enables the A output, bit 4 enables the B output, and bit 5 is the level driven on B.
- R12: The counter (word ch*8+3) reads back zero-extended. Read data appears on bus_rdata in the cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| slow_clk | input | 1 | Slow clock, asynchronous |
| tclk | input | 3 | External clock pins for XC0..XC2 |
| tio_a_in | input | 3 | A line input level per channel |
| tio_a_out | output | 3 | A line output level per channel |
| tio_a_oe | output | 3 | A line output enable per channel |
| tio_b_in | input | 3 | B line input level per channel |
| tio_b_out | output | 3 | B line output level per channel |
| tio_b_oe | output | 3 | B line output enable per channel |
| irq | output | 3 | Interrupt per channel |

## Verification
The assertions assume that software never writes a trigger and a stop in the same word. They also assume that each external clock line, slow clock and timer input is held for at least two system clocks per level, so that the synchronizers see every edge. The bench drives those pins on the falling edge and holds each level for four cycles. It gives each bus access a single cycle of strobe. It checks prescaled counts inside a small tolerance, because the phase of the free-running divider is not visible at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NUM_DIV  = 4;
   localparam int NUM_INT  = NUM_DIV + 1;
   localparam int NUM_XC   = 3;
   localparam int SEL_W    = 3;
   localparam int DIV_LOG2 [NUM_DIV] = '{1, 3, 5, 7};

   localparam int CH_STRIDE = 8;
   localparam int OFF_CTRL  = 0;
   localparam int OFF_MODE  = 1;
   localparam int OFF_CMP   = 2;
   localparam int OFF_CNT   = 3;
   localparam int OFF_STAT  = 4;
   localparam int OFF_IEN   = 5;

   localparam int FLAG_W    = 2;
   localparam int MODE_W    = 7;

   typedef struct packed {
      logic             reload_on_match;
      logic             b_level;
      logic             b_drive;
      logic             a_drive;
      logic [SEL_W-1:0] src;
   } ch_mode_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("tmr_sync width must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int MAX_LOG2 = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               slow_lvl,
   output logic [NUM_INT-1:0] tick
);
   if (DIV_LOG2[NUM_DIV-1] > MAX_LOG2) begin : g_bad_div
      $error("prescaler divider too narrow for largest ratio");
   end

   logic [MAX_LOG2-1:0] div_q;
   logic [NUM_DIV-1:0]  div_nxt;
   logic [NUM_DIV-1:0]  div_tick_q;
   logic                slow_prev_q;
   logic                slow_tick_q;

   for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
      localparam logic [MAX_LOG2-1:0] LOW_MASK =
         MAX_LOG2'((64'd1 << DIV_LOG2[i]) - 64'd1);
      assign div_nxt[i] = (div_q & LOW_MASK) == LOW_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q       <= '0;
         div_tick_q  <= '0;
         slow_prev_q <= 1'b0;
         slow_tick_q <= 1'b0;
      end else begin
         div_q       <= div_q + 1'b1;
         div_tick_q  <= div_nxt;
         slow_prev_q <= slow_lvl;
         slow_tick_q <= slow_lvl & ~slow_prev_q;
      end
   end

   assign tick = {slow_tick_q, div_tick_q};

   // R3: a slower enable always coincides with every faster one
   p_nested_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[3] |-> (tick[2] && tick[1] && tick[0]));
   // R3: divide-by-2 enable alternates
   p_half_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[0] |=> !tick[0]);
   // R3: slow clock edge enable is a single-cycle pulse
   p_slow_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[4] |=> !tick[4]);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_INT-1:0] int_tick,
   input  logic [NUM_XC-1:0]  xc_tick,
   input  ch_mode_t           mode,
   input  logic [CNT_W-1:0]   cmp_val,
   input  logic               trig,
   input  logic               stop,
   input  logic               clr_flags,
   input  logic [FLAG_W-1:0]  ien,
   output logic [CNT_W-1:0]   cnt,
   output logic [FLAG_W-1:0]  flags,
   output logic               running,
   output logic               a_level,
   output logic               irq
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr_channel counter too narrow");
   end

   logic tick_sel;
   logic adv;
   logic hit;
   logic wrap;

   always_comb begin
      case (mode.src)
         3'd0:    tick_sel = int_tick[0];
         3'd1:    tick_sel = int_tick[1];
         3'd2:    tick_sel = int_tick[2];
         3'd3:    tick_sel = int_tick[3];
         3'd4:    tick_sel = int_tick[4];
         3'd5:    tick_sel = xc_tick[0];
         3'd6:    tick_sel = xc_tick[1];
         default: tick_sel = xc_tick[2];
      endcase
   end

   assign adv  = running & tick_sel & ~trig;
   assign hit  = adv & (cnt == cmp_val);
   assign wrap = adv & (cnt == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         a_level <= 1'b0;
      end else if (trig) begin
         cnt     <= '0;
         running <= 1'b1;
         a_level <= 1'b0;
      end else begin
         if (stop) running <= 1'b0;
         if (adv) begin
            if (hit && mode.reload_on_match) cnt <= '0;
            else                             cnt <= cnt + 1'b1;
         end
         if (hit) a_level <= ~a_level;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~{FLAG_W{clr_flags}}) | {hit, wrap};
   end

   assign irq = |(flags & ien);

   // R2: a trigger leaves the counter at zero and running
   p_trig_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (cnt == '0) && running);
   // R2: a stopped counter holds its value
   p_stop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !trig) |=> $stable(cnt));
   // R3: no enable, no movement
   p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_sel && !trig) |=> $stable(cnt));
   // R5: overflow flag stays until a status read
   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !clr_flags) |=> flags[0]);
   // R5: wrapping lands on zero
   p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0) && flags[0]);
   // R6: a match toggles the A line level
   p_match_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (a_level != $past(a_level)) && flags[1]);
   // R7: a read with no new event leaves both flags clear
   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flags && !hit && !wrap) |=> (flags == '0));
   // R8: an interrupt needs an enabled flag
   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((ien & flags) != '0));
endmodule

// File: rtl/tmr_block.sv
module tmr_block
   import tmr_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int SYNC_ST = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              slow_clk,
   input  logic [NUM_XC-1:0] tclk,
   input  logic [NUM_CH-1:0] tio_a_in,
   output logic [NUM_CH-1:0] tio_a_out,
   output logic [NUM_CH-1:0] tio_a_oe,
   input  logic [NUM_CH-1:0] tio_b_in,
   output logic [NUM_CH-1:0] tio_b_out,
   output logic [NUM_CH-1:0] tio_b_oe,
   output logic [NUM_CH-1:0] irq
);
   localparam int BLK_CTRL_W = NUM_CH * CH_STRIDE;
   localparam int BLK_MODE_W = BLK_CTRL_W + 1;
   localparam logic [ADDR_W-1:0] A_BCTRL = ADDR_W'(BLK_CTRL_W);
   localparam logic [ADDR_W-1:0] A_BMODE = ADDR_W'(BLK_MODE_W);

   if (BLK_MODE_W >= (1 << ADDR_W)) begin : g_bad_addr
      $error("address width too small for register map");
   end
   if (CNT_W > DATA_W || DATA_W < 11) begin : g_bad_data
      $error("data width too small for counter or status");
   end
   if (NUM_CH < 2) begin : g_bad_ch
      $error("chaining needs at least two channels");
   end

   logic [NUM_INT-1:0]  int_tick;
   logic                slow_s;
   logic [NUM_XC-1:0]   tclk_s;
   logic [NUM_CH-1:0]   a_in_s;
   logic [NUM_CH-1:0]   b_in_s;
   logic [NUM_XC-1:0]   chain_q;
   logic [NUM_XC-1:0]   xc_lvl;
   logic [NUM_XC-1:0]   xc_prev_q;
   logic [NUM_XC-1:0]   xc_tick;
   logic [NUM_CH-1:0]   a_lvl;
   logic [NUM_CH-1:0]   run_vec;
   logic [NUM_CH-1:0]   zero_vec;
   logic [DATA_W-1:0]   rd_part [NUM_CH];
   logic [DATA_W-1:0]   rd_blk;
   logic [DATA_W-1:0]   rd_nxt;
   logic                blk_start;

   tmr_sync #(.WIDTH(1), .STAGES(SYNC_ST)) u_sync_slow (
      .clk(clk), .rst_n(rst_n), .d_async(slow_clk), .q_sync(slow_s));
   tmr_sync #(.WIDTH(NUM_XC), .STAGES(SYNC_ST)) u_sync_tclk (
      .clk(clk), .rst_n(rst_n), .d_async(tclk), .q_sync(tclk_s));
   tmr_sync #(.WIDTH(2*NUM_CH), .STAGES(SYNC_ST)) u_sync_tio (
      .clk(clk), .rst_n(rst_n), .d_async({tio_b_in, tio_a_in}),
      .q_sync({b_in_s, a_in_s}));

   tmr_prescaler #(.MAX_LOG2(DIV_LOG2[NUM_DIV-1])) u_presc (
      .clk(clk), .rst_n(rst_n), .slow_lvl(slow_s), .tick(int_tick));

   assign blk_start = bus_wr && (bus_addr == A_BCTRL) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          chain_q <= '0;
      else if (bus_wr && bus_addr == A_BMODE) chain_q <= bus_wdata[NUM_XC-1:0];
   end

   for (genvar x = 0; x < NUM_XC; x++) begin : g_xc
      localparam int SRC_CH = (x + NUM_CH - 1) % NUM_CH;
      assign xc_lvl[x] = chain_q[x] ? a_lvl[SRC_CH] : tclk_s[x];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) xc_prev_q <= '0;
      else        xc_prev_q <= xc_lvl;
   end
   assign xc_tick = xc_lvl & ~xc_prev_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(c*CH_STRIDE + OFF_CTRL);
      localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(c*CH_STRIDE + OFF_MODE);
      localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(c*CH_STRIDE + OFF_CMP);
      localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(c*CH_STRIDE + OFF_CNT);
      localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(c*CH_STRIDE + OFF_STAT);
      localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(c*CH_STRIDE + OFF_IEN);

      ch_mode_t            mode_q;
      logic [CNT_W-1:0]    cmp_q;
      logic [FLAG_W-1:0]   ien_q;
      logic [CNT_W-1:0]    cnt;
      logic [FLAG_W-1:0]   flags;
      logic                wr_ctrl;
      logic                trig;
      logic                stop;
      logic                clr;
      logic [DATA_W-1:0]   rd_c;

      assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
      assign trig    = (wr_ctrl && bus_wdata[0]) || blk_start;
      assign stop    = wr_ctrl && bus_wdata[1];
      assign clr     = bus_rd && (bus_addr == A_STAT);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= '0;
            cmp_q  <= '0;
            ien_q  <= '0;
         end else if (bus_wr) begin
            if (bus_addr == A_MODE) mode_q <= ch_mode_t'(bus_wdata[MODE_W-1:0]);
            if (bus_addr == A_CMP)  cmp_q  <= bus_wdata[CNT_W-1:0];
            if (bus_addr == A_IEN)  ien_q  <= bus_wdata[FLAG_W-1:0];
         end
      end

      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .int_tick(int_tick), .xc_tick(xc_tick),
         .mode(mode_q), .cmp_val(cmp_q),
         .trig(trig), .stop(stop), .clr_flags(clr), .ien(ien_q),
         .cnt(cnt), .flags(flags), .running(run_vec[c]),
         .a_level(a_lvl[c]), .irq(irq[c]));

      assign zero_vec[c]  = (cnt == '0);
      assign tio_a_out[c] = a_lvl[c];
      assign tio_a_oe[c]  = mode_q.a_drive;
      assign tio_b_out[c] = mode_q.b_level;
      assign tio_b_oe[c]  = mode_q.b_drive;

      always_comb begin
         rd_c = '0;
         if (bus_addr == A_MODE) rd_c = DATA_W'(mode_q);
         if (bus_addr == A_CMP)  rd_c = DATA_W'(cmp_q);
         if (bus_addr == A_CNT)  rd_c = DATA_W'(cnt);
         if (bus_addr == A_STAT)
            rd_c = DATA_W'({b_in_s[c], a_in_s[c], run_vec[c], 6'b0, flags});
         if (bus_addr == A_IEN)  rd_c = DATA_W'(ien_q);
      end
      assign rd_part[c] = rd_c;
   end

   assign rd_blk = (bus_addr == A_BMODE) ? DATA_W'(chain_q) : '0;

   always_comb begin
      rd_nxt = rd_blk;
      for (int c = 0; c < NUM_CH; c++) rd_nxt = rd_nxt | rd_part[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_nxt;
   end

   // R9: block start clears and starts every channel on one edge
   p_block_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> (&run_vec) && (&zero_vec));
   // R4: external clock enables are single-cycle pulses
   p_xc_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xc_tick != '0) |=> ((xc_tick & $past(xc_tick)) == '0));
   // R12: read data only changes after a read strobe
   p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tmr_block_test.sv
module tmr_block_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        slow_clk = 1'b0;
   logic [2:0]  tclk = '0;
   logic [2:0]  tio_a_in = '0;
   logic [2:0]  tio_a_out;
   logic [2:0]  tio_a_oe;
   logic [2:0]  tio_b_in = '0;
   logic [2:0]  tio_b_out;
   logic [2:0]  tio_b_oe;
   logic [2:0]  irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   tmr_block uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .slow_clk(slow_clk), .tclk(tclk),
      .tio_a_in(tio_a_in), .tio_a_out(tio_a_out), .tio_a_oe(tio_a_oe),
      .tio_b_in(tio_b_in), .tio_b_out(tio_b_out), .tio_b_oe(tio_b_oe),
      .irq(irq));

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_range(input string req, input logic [31:0] act,
                              input int lo, input int hi);
      checks++;
      if (int'(act) < lo || int'(act) > hi) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   function automatic logic [4:0] ra(input int ch, input int off);
      return 5'(ch*8 + off);
   endfunction

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_tclk(input int idx, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tclk[idx] = 1'b1;
         repeat (4) @(negedge clk);
         tclk[idx] = 1'b0;
         repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int c = 0; c < 3; c++) begin
         rd(ra(c, 3), d); check("R1 count after reset", d, 0);
         rd(ra(c, 4), d); check("R1 status after reset", d, 0);
      end
      check("R1 irq after reset", 32'(irq), 0);
      check("R1 output enables after reset", 32'({tio_a_oe, tio_b_oe}), 0);
   endtask

   task automatic t_compare();
      logic [31:0] d;
      wr(ra(0, 1), 32'h0D);           // source XC0, A output driven
      wr(ra(0, 2), 32'd3);
      wr(ra(0, 0), 32'h1);
      pulse_tclk(0, 3);
      rd(ra(0, 3), d); check("R4 count of external edges", d, 3);
      rd(ra(0, 4), d); check("R7 status running, no flags", d, 32'h100);
      pulse_tclk(0, 1);
      rd(ra(0, 3), d); check("R6 count continues past match", d, 4);
      check("R6 A line toggled", 32'(tio_a_out[0]), 1);
      check("R11 A output enabled", 32'(tio_a_oe[0]), 1);
      rd(ra(0, 4), d); check("R6 compare flag", d & 32'h3, 2);
      rd(ra(0, 4), d); check("R7 flags cleared by read", d & 32'h3, 0);
   endtask

   task automatic t_reload();
      logic [31:0] d;
      wr(ra(0, 1), 32'h45);           // XC0, reload on match
      wr(ra(0, 2), 32'd2);
      wr(ra(0, 0), 32'h1);
      pulse_tclk(0, 3);
      rd(ra(0, 3), d); check("R6 reload to zero on match", d, 0);
      rd(ra(0, 4), d); check("R6 compare flag on reload", d & 32'h3, 2);
      pulse_tclk(0, 1);
      rd(ra(0, 3), d); check("R6 counting after reload", d, 1);
   endtask

   task automatic t_trig_stop();
      logic [31:0] d;
      wr(ra(0, 1), 32'h05);
      wr(ra(0, 2), 32'hFFFE);
      wr(ra(0, 0), 32'h1);
      rd(ra(0, 3), d); check("R2 trigger clears count", d, 0);
      pulse_tclk(0, 2);
      rd(ra(0, 3), d); check("R2 counting after trigger", d, 2);
      wr(ra(0, 0), 32'h2);
      pulse_tclk(0, 2);
      rd(ra(0, 3), d); check("R2 stopped count holds", d, 2);
      rd(ra(0, 4), d); check("R2 running bit clear after stop", d & 32'h100, 0);
   endtask

   task automatic t_block_start();
      logic [31:0] d;
      for (int c = 0; c < 3; c++) wr(ra(c, 1), 32'h07);
      wr(5'd25, 32'h0);
      wr(5'd24, 32'h1);
      pulse_tclk(2, 2);
      for (int c = 0; c < 3; c++) begin
         rd(ra(c, 3), d); check("R9 block start counts in step", d, 2);
      end
   endtask

   task automatic t_chain();
      logic [31:0] d;
      wr(ra(0, 1), 32'h45);           // XC0, reload on match
      wr(ra(0, 2), 32'd0);
      wr(ra(1, 1), 32'h06);           // XC1
      wr(5'd25, 32'h2);
      rd(5'd25, d); check("R10 block mode readback", d, 2);
      wr(5'd24, 32'h1);
      pulse_tclk(0, 6);
      rd(ra(1, 3), d); check("R10 chained channel counts A edges", d, 3);
      rd(ra(0, 3), d); check("R10 source channel reloads each edge", d, 0);
      wr(5'd25, 32'h0);
   endtask

   task automatic t_tio();
      logic [31:0] d;
      wr(ra(2, 1), 32'h30);
      check("R11 B output enable", 32'(tio_b_oe[2]), 1);
      check("R11 B output level", 32'(tio_b_out[2]), 1);
      check("R11 A output disabled", 32'(tio_a_oe[2]), 0);
      @(negedge clk); tio_a_in[1] = 1'b1; tio_b_in[1] = 1'b0;
      repeat (4) @(negedge clk);
      rd(ra(1, 4), d); check("R7 input levels in status", d & 32'h600, 32'h200);
   endtask

   task automatic t_slow();
      logic [31:0] d;
      wr(ra(1, 1), 32'h04);
      wr(ra(1, 0), 32'h1);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); slow_clk = 1'b1;
         repeat (4) @(negedge clk);
         slow_clk = 1'b0;
         repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      rd(ra(1, 3), d); check("R3 slow clock edges counted", d, 5);
   endtask

   task automatic t_prescale(input int code, input int div);
      logic [31:0] d;
      wr(ra(1, 1), 32'(code));
      wr(ra(1, 0), 32'h1);
      repeat (100*div) @(negedge clk);
      wr(ra(1, 0), 32'h2);
      rd(ra(1, 3), d);
      check_range($sformatf("R3 divide by %0d rate", div), d, 98, 102);
   endtask

   task automatic t_overflow();
      logic [31:0] d;
      wr(ra(2, 1), 32'h00);
      wr(ra(2, 2), 32'hFFFF);
      wr(ra(2, 5), 32'h0);
      wr(ra(2, 0), 32'h1);
      repeat (131200) @(negedge clk);
      wr(ra(2, 0), 32'h2);
      check("R8 masked flag keeps irq low", 32'(irq[2]), 0);
      wr(ra(2, 5), 32'h1);
      check("R8 enabled flag raises irq", 32'(irq[2]), 1);
      rd(ra(2, 3), d); check_range("R5 count wrapped", d, 50, 80);
      rd(ra(2, 4), d); check("R5 overflow flag", d & 32'h1, 1);
      check("R8 irq drops after read", 32'(irq[2]), 0);
      rd(ra(2, 4), d); check("R7 overflow cleared", d & 32'h3, 0);
      rd(ra(2, 2), d); check("R12 compare readback", d, 32'hFFFF);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_compare();
      t_reload();
      t_trig_stop();
      t_block_start();
      t_chain();
      t_tio();
      t_slow();
      t_prescale(1, 8);
      t_prescale(2, 32);
      t_prescale(3, 128);
      t_overflow();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule